// File: doc/BRIEF.md
# Delayed-Parity Command Error Checker

This block watches a 22-bit command word and a parity bit that arrives one clock after the word it covers. The word is captured on one rising edge. Its parity bit is captured on the next edge. The XOR of all data bits together with that parity bit is then registered as the compare result. A result of 1 means a mismatch. A mismatch pulls an active-low error flag down one clock later.

A comparison is only made for words that were captured while at least one of the two active-low chip selects was asserted. The qualifier travels down the pipeline alongside its word. A detected error holds the flag low for two cycles, and a further error restarts that hold. Once the hold has run out, the flag returns high on the next checked clean word. If only unselected cycles follow, the flag keeps its value.

An asynchronous active-low reset forces the flag high at once and clears the hold. The internal release of that reset is synchronised to the clock.

Top module: `delayed_parity_checker`

## Requirements
- R1: While `rst_n` is low the flag `err_n` is 1, and it becomes 1 without waiting for a clock edge. After reset is released it stays 1 until an error is detected.
- R2: A checked word is in error exactly when the XOR of its 22 data bits and its parity bit is 1. An even number of ones with parity 0 passes, and an odd number of ones with parity 1 passes.
- R3: The parity bit that applies to a word is the value of `par_in` on the rising edge after the one that captured the word, not the value on the same edge.
- R4: For an erroneous word captured at edge n, `err_n` is 0 right after edge n+3.
- R5: After an error, `err_n` stays 0 right after edge n+4 as well (a two-cycle low pulse). It returns to 1 at the first later edge where the hold is over and a checked clean word is evaluated.
- R6: An error found while the flag is already low restarts the two-cycle hold, so back-to-back errors give one continuous low period.
- R7: A word captured with both `sel_n` bits at 1 is not checked. Its parity is ignored, and outside an active hold the flag keeps its previous value, whether high or low, at that word's evaluation edge.
- R8: A word is checked when either bit of `sel_n` is 0: bit 0 alone, bit 1 alone, or both.
- R9: Asserting reset while the flag is low in the middle of a hold drives it high at once. After release, no remnant of the earlier hold or pipeline appears on the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_data | input | 22 | Command word captured on each rising edge |
| sel_n | input | 2 | Active-low chip selects; either low marks the word as checked |
| par_in | input | 1 | Parity bit for the word captured on the previous edge |
| err_n | output | 1 | Active-low parity error flag |

## Verification
Clean streams of varied words, including all-zero, all-ones and single-bit words, show that matching parity never pulls the flag down. Single flipped parity bits fix the three-edge latency and the two-cycle width. Parity that is correct for the current word but wrong for the previous one shows that the checker uses the lagged bit. Consecutive and closely spaced errors distinguish a restarted hold from two separate pulses. Unselected words carrying bad parity, and unselected gaps after an error, show that gating neither raises nor clears the flag. Each select asserted alone confirms that either one enables the check, and a reset during a low pulse confirms that the hold is cleared.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int DPC_DATA_W = 22;
  localparam int DPC_SEL_W  = 2;
  localparam int DPC_HOLD   = 2;

  function automatic int dpc_cnt_w(input int hold);
    return (hold < 2) ? 1 : $clog2(hold + 1);
  endfunction
endpackage

// File: rtl/dpc_rst_sync.sv
module dpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dpc_capture.sv
module dpc_capture #(
  parameter int DATA_W = 22,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [SEL_W-1:0]  sel_n,
  input  logic              par_in,
  output logic [DATA_W-1:0] word_q,
  output logic              word_act_q,
  output logic              word_par_q
);
  logic              act_now;
  logic [DATA_W-1:0] stg0_data_q;
  logic              stg0_act_q;
  logic              stg0_en;
  logic              stg1_en;

  assign act_now = ~(&sel_n);
  assign stg0_en = act_now;
  assign stg1_en = stg0_act_q;

  // stage 0: word and qualifier at edge n; data loads only for selected words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg0_data_q <= '0;
      stg0_act_q  <= 1'b0;
    end else begin
      stg0_act_q <= act_now;
      if (stg0_en) stg0_data_q <= cmd_data;
    end
  end

  // stage 1: word realigned with its lagging parity bit at edge n+1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      word_par_q <= 1'b0;
      word_act_q <= 1'b0;
    end else begin
      word_act_q <= stg0_act_q;
      if (stg1_en) begin
        word_q     <= stg0_data_q;
        word_par_q <= par_in;
      end
    end
  end
endmodule

// File: rtl/dpc_compare.sv
module dpc_compare #(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word_q,
  input  logic              word_act_q,
  input  logic              word_par_q,
  output logic              cmp_vld,
  output logic              cmp_err
);
  localparam int HALF_W = DATA_W / 2;

  logic lo_x, hi_x, mis_nxt;

  generate
    if (DATA_W > 1) begin : g_split
      assign lo_x = ^word_q[HALF_W-1:0];
      assign hi_x = ^word_q[DATA_W-1:HALF_W];
    end else begin : g_single
      assign lo_x = word_q[0];
      assign hi_x = 1'b0;
    end
  endgenerate

  assign mis_nxt = lo_x ^ hi_x ^ word_par_q;

  // edge n+2: registered compare result and its qualifier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_vld <= 1'b0;
      cmp_err <= 1'b0;
    end else begin
      cmp_vld <= word_act_q;
      if (word_act_q) cmp_err <= mis_nxt;
      else            cmp_err <= 1'b0;
    end
  end
endmodule

// File: rtl/dpc_err_hold.sv
module dpc_err_hold #(
  parameter int HOLD  = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_vld,
  input  logic             cmp_err,
  output logic [CNT_W-1:0] hold_cnt,
  output logic             err_n
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD - 1);

  logic             flag_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    flag_nxt = err_n;
    cnt_nxt  = hold_cnt;
    if (cmp_vld && cmp_err) begin
      flag_nxt = 1'b0;
      cnt_nxt  = RELOAD;
    end else if (hold_cnt != '0) begin
      flag_nxt = 1'b0;
      cnt_nxt  = hold_cnt - CNT_W'(1);
    end else if (cmp_vld) begin
      flag_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_n    <= 1'b1;
      hold_cnt <= '0;
    end else begin
      err_n    <= flag_nxt;
      hold_cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/delayed_parity_checker.sv
module delayed_parity_checker
  import dpc_pkg::*;
#(
  parameter int DATA_W = DPC_DATA_W,
  parameter int SEL_W  = DPC_SEL_W,
  parameter int HOLD   = DPC_HOLD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [SEL_W-1:0]  sel_n,
  input  logic              par_in,
  output logic              err_n
);
  localparam int CNT_W = dpc_cnt_w(HOLD);

  logic              rst_int;
  logic [DATA_W-1:0] word_q;
  logic              word_act_q;
  logic              word_par_q;
  logic              cmp_vld;
  logic              cmp_err;
  logic [CNT_W-1:0]  hold_cnt;
  logic              flag_q;

  dpc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int)
  );

  dpc_capture #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_int),
    .cmd_data   (cmd_data),
    .sel_n      (sel_n),
    .par_in     (par_in),
    .word_q     (word_q),
    .word_act_q (word_act_q),
    .word_par_q (word_par_q)
  );

  dpc_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_int),
    .word_q     (word_q),
    .word_act_q (word_act_q),
    .word_par_q (word_par_q),
    .cmp_vld    (cmp_vld),
    .cmp_err    (cmp_err)
  );

  dpc_err_hold #(.HOLD(HOLD), .CNT_W(CNT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_int),
    .cmp_vld  (cmp_vld),
    .cmp_err  (cmp_err),
    .hold_cnt (hold_cnt),
    .err_n    (flag_q)
  );

  // the asynchronous assertion of the port reset reaches the flag directly
  assign err_n = flag_q | ~rst_n;
endmodule

// File: rtl/dpc_sva.sv
module dpc_sva #(
  parameter int DATA_W = 22,
  parameter int SEL_W  = 2,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_int,
  input logic [DATA_W-1:0] cmd_data,
  input logic [SEL_W-1:0]  sel_n,
  input logic              par_in,
  input logic              cmp_vld,
  input logic              cmp_err,
  input logic [CNT_W-1:0]  hold_cnt,
  input logic              err_n
);
  logic [2:0] live_cyc;

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)             live_cyc <= 3'd0;
    else if (live_cyc != 3'd7) live_cyc <= live_cyc + 3'd1;
  end

  always_comb begin
    if (!rst_n) AST_RESET_FLAG_HIGH: assert (err_n === 1'b1); // R1
  end

  AST_LAGGED_PARITY: assert property (@(posedge clk) disable iff (!rst_int)
    (live_cyc >= 3'd5 && $past(~(&sel_n), 3))
      |-> (cmp_err == ($past(^cmd_data, 3) ^ $past(par_in, 2)))); // R3

  AST_SELECT_QUALIFIER: assert property (@(posedge clk) disable iff (!rst_int)
    (live_cyc >= 3'd5) |-> (cmp_vld == $past(~(&sel_n), 3))); // R8

  AST_ERROR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n || !rst_int)
    (cmp_vld && cmp_err) |=> !err_n); // R4

  AST_TWO_CYCLE_LOW: assert property (@(posedge clk) disable iff (!rst_n || !rst_int)
    $fell(err_n) |=> !err_n); // R5

  AST_GATED_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !rst_int)
    (!cmp_vld && hold_cnt == '0) |=> $stable(err_n)); // R7

  AST_CLEAN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n || !rst_int)
    (cmp_vld && !cmp_err && hold_cnt == '0) |=> err_n); // R5
endmodule

bind delayed_parity_checker dpc_sva #(
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W),
  .CNT_W  (dpc_pkg::dpc_cnt_w(HOLD))
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_int  (rst_int),
  .cmd_data (cmd_data),
  .sel_n    (sel_n),
  .par_in   (par_in),
  .cmp_vld  (cmp_vld),
  .cmp_err  (cmp_err),
  .hold_cnt (hold_cnt),
  .err_n    (err_n)
);

// File: tb/tb_delayed_parity_checker.sv
module tb_delayed_parity_checker;
  localparam int DW   = 22;
  localparam int HOLD = 2;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] cmd_data;
  logic [1:0]    sel_n;
  logic          par_in;
  logic          err_n;

  always #5 clk = ~clk;

  delayed_parity_checker dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_data (cmd_data),
    .sel_n    (sel_n),
    .par_in   (par_in),
    .err_n    (err_n)
  );

  item_t         q[$];
  item_t         mon_it;
  int            n_tests = 0;
  int            n_fail  = 0;
  string         cur_tag = "R1";
  logic [DW-1:0] d_h[4];
  logic          a_h[4];
  logic          p_h[3];
  logic          m_flag;
  int            m_cnt;
  logic [DW-1:0] last_d;
  logic [31:0]   seed = 32'h1234_5678;

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: err_n=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:9];
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      d_h[i] = '0;
      a_h[i] = 1'b0;
    end
    for (int i = 0; i < 3; i++) p_h[i] = 1'b0;
    m_flag = 1'b1;
    m_cnt  = 0;
    last_d = '0;
  endtask

  // one word per clock; p is the parity for the word of the previous beat
  task automatic beat_raw(input logic [DW-1:0] d, input logic [1:0] s, input logic p);
    item_t it;
    logic  chk_act;
    logic  chk_err;
    @(negedge clk);
    cmd_data = d;
    sel_n    = s;
    par_in   = p;
    for (int i = 3; i > 0; i--) begin
      d_h[i] = d_h[i-1];
      a_h[i] = a_h[i-1];
    end
    for (int i = 2; i > 0; i--) p_h[i] = p_h[i-1];
    d_h[0] = d;
    a_h[0] = (s != 2'b11);
    p_h[0] = p;
    // evaluation edge for the word captured three edges earlier
    chk_act = a_h[3];
    chk_err = (^d_h[3]) ^ p_h[2];
    if (chk_act && chk_err) begin
      m_flag = 1'b0;
      m_cnt  = HOLD - 1;
    end else if (m_cnt != 0) begin
      m_cnt  = m_cnt - 1;
      m_flag = 1'b0;
    end else if (chk_act) begin
      m_flag = 1'b1;
    end
    it.exp = m_flag;
    it.tag = cur_tag;
    q.push_back(it);
    last_d = d;
  endtask

  task automatic beat(input logic [DW-1:0] d, input logic [1:0] s, input bit flip);
    beat_raw(d, s, (^last_d) ^ flip);
  endtask

  task automatic do_reset(input bit was_low);
    @(negedge clk);
    if (was_low) check(err_n, 1'b0, "R9 flag low before reset");
    #1 rst_n = 1'b0;
    q.delete();
    model_clear();
    cmd_data = '0;
    sel_n    = 2'b11;
    par_in   = 1'b0;
    #1 check(err_n, 1'b1, "R9 immediate high on reset");
    repeat (3) @(negedge clk);
    check(err_n, 1'b1, "R1 high during reset");
    rst_n = 1'b1;
    cur_tag = "R1 after release";
    repeat (3) beat(22'h0, 2'b11, 1'b0);
  endtask

  // scoreboard monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        mon_it = q.pop_front();
        check(err_n, mon_it.exp, mon_it.tag);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: err_n=%0b expected run end", err_n);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    cmd_data = '0;
    sel_n    = 2'b11;
    par_in   = 1'b0;
    model_clear();
    #1 check(err_n, 1'b1, "R1 reset at time zero");
    repeat (3) @(negedge clk);
    check(err_n, 1'b1, "R1 reset state");
    rst_n = 1'b1;
    cur_tag = "R1 after release";
    repeat (3) beat(22'h0, 2'b11, 1'b0);

    // R2: clean traffic with varied one-counts
    cur_tag = "R2 clean stream";
    beat(22'h0, 2'b10, 1'b0);
    beat(22'h3F_FFFF, 2'b10, 1'b0);
    beat(22'h1, 2'b10, 1'b0);
    beat(22'h20_0000, 2'b10, 1'b0);
    for (int i = 0; i < 12; i++) beat(rnd(), 2'b10, 1'b0);
    cur_tag = "R2 single flipped parity";
    beat(rnd(), 2'b10, 1'b1);
    for (int i = 0; i < 6; i++) beat(rnd(), 2'b10, 1'b0);

    // R3: parity matching the current word instead of the previous one
    cur_tag = "R3 same-edge parity ignored";
    beat(22'h0, 2'b10, 1'b0);
    beat_raw(22'h7, 2'b10, 1'b1);
    beat_raw(22'h0, 2'b10, 1'b0);
    for (int i = 0; i < 6; i++) beat(rnd(), 2'b10, 1'b0);

    // R4 and R5: latency and pulse width of an isolated error
    cur_tag = "R4 R5 isolated error";
    beat(22'h15, 2'b10, 1'b0);
    beat(rnd(), 2'b10, 1'b1);
    for (int i = 0; i < 7; i++) beat(rnd(), 2'b10, 1'b0);

    // R6: consecutive errors and errors one word apart
    cur_tag = "R6 back-to-back errors";
    beat(rnd(), 2'b10, 1'b1);
    beat(rnd(), 2'b10, 1'b1);
    beat(rnd(), 2'b10, 1'b1);
    for (int i = 0; i < 6; i++) beat(rnd(), 2'b10, 1'b0);
    cur_tag = "R6 errors one word apart";
    beat(rnd(), 2'b10, 1'b1);
    beat(rnd(), 2'b10, 1'b0);
    beat(rnd(), 2'b10, 1'b1);
    for (int i = 0; i < 6; i++) beat(rnd(), 2'b10, 1'b0);

    // R7: unselected words with bad parity; unselected gap after an error
    cur_tag = "R7 gated bad parity ignored";
    beat(rnd(), 2'b11, 1'b0);
    beat(rnd(), 2'b11, 1'b1);
    beat(rnd(), 2'b11, 1'b1);
    beat(rnd(), 2'b10, 1'b1);
    for (int i = 0; i < 6; i++) beat(rnd(), 2'b10, 1'b0);
    cur_tag = "R7 low flag kept across gated gap";
    beat(rnd(), 2'b10, 1'b0);
    beat(rnd(), 2'b11, 1'b1);
    for (int i = 0; i < 6; i++) beat(rnd(), 2'b11, 1'b0);
    for (int i = 0; i < 5; i++) beat(rnd(), 2'b10, 1'b0);

    // R8: each select alone and both together enable the check
    cur_tag = "R8 select bit0 only";
    beat(rnd(), 2'b10, 1'b0);
    beat(rnd(), 2'b11, 1'b1);
    for (int i = 0; i < 5; i++) beat(rnd(), 2'b11, 1'b0);
    beat(rnd(), 2'b10, 1'b0);
    for (int i = 0; i < 4; i++) beat(rnd(), 2'b10, 1'b0);
    cur_tag = "R8 select bit1 only";
    beat(rnd(), 2'b01, 1'b0);
    beat(rnd(), 2'b01, 1'b1);
    for (int i = 0; i < 6; i++) beat(rnd(), 2'b01, 1'b0);
    cur_tag = "R8 both selects";
    beat(rnd(), 2'b00, 1'b0);
    beat(rnd(), 2'b00, 1'b1);
    for (int i = 0; i < 6; i++) beat(rnd(), 2'b00, 1'b0);

    // R9: reset in the middle of a low pulse
    cur_tag = "R9 error before reset";
    beat(rnd(), 2'b10, 1'b0);
    beat(rnd(), 2'b10, 1'b1);
    beat(rnd(), 2'b10, 1'b0);
    beat(rnd(), 2'b10, 1'b0);
    do_reset(1'b1);
    cur_tag = "R9 clean after reset";
    for (int i = 0; i < 8; i++) beat(rnd(), 2'b10, 1'b0);
    cur_tag = "R9 error after reset";
    beat(rnd(), 2'b10, 1'b1);
    for (int i = 0; i < 6; i++) beat(rnd(), 2'b10, 1'b0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule